// File: doc/BRIEF.md
# Two-Stage Decoupled Mini Core

This block is a small 16-bit processor split into two stages. A short queue of already-decoded operations sits between them. The front stage reads the word at the program counter from a preloadable program array. It reads the register file for the source operands and pushes a decoded operation into the queue. That operation carries the operand values themselves, not register names. The back stage pops the queue head, performs it, and writes the register file. It also resolves conditional branches and moves words to an output port or from an input port.

The front stage holds off whenever an operand it needs is still to be written by an operation waiting in the queue. It also holds off while a branch sits in the queue, so it never runs ahead of an unresolved branch. A taken branch redirects the program counter and discards the whole queue. The program array is written through a simple write port, normally while reset is held. Execution starts at address 0 when reset is released.

Top module: `duo_core`

## Requirements
- R1: After synchronous active-high reset the program counter is 0, all four registers read 0, the queue is empty, and `out_valid` and `in_ack` are low.
- R2: An instruction word has the opcode in bits [15:13], the destination in [12:11], the first source in [10:9] and the second source in [8:7]. Opcode 0 loads bits [10:0], sign-extended to 16 bits, into the destination. Opcode 1 loads the instruction's own address into the destination.
- R3: Opcode 2 writes first source + second source, and opcode 3 writes first source − second source, into the destination, both modulo 2^16.
- R4: An instruction is not fetched while any queued entry will write one of the registers it reads. Results always equal strictly sequential execution.
- R5: Opcode 4 tests the first source and takes the second source as the target. If the test value is 0, the program counter is loaded with the target, the queue is cleared and nothing is enqueued in that cycle. Otherwise the branch has no effect. No instruction is fetched while a branch is queued.
- R6: Opcode 5 presents the first source value on `out_data`, with `out_valid` high for exactly one cycle per executed instruction.
- R7: Opcode 6 waits at the queue head until `in_valid` is high. It then loads `in_data` into the destination, with `in_ack` high in that cycle only.
- R8: The queue holds `QDEPTH` entries (default 2). Nothing is enqueued while it is full. It can enqueue and dequeue in the same cycle.
- R9: Opcode 7 changes no register and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_we | input | 1 | Program array write enable |
| pm_addr | input | PM_AW | Program array write address |
| pm_wdata | input | 16 | Program array write data |
| in_valid | input | 1 | Input port word available |
| in_data | input | 16 | Input port word |
| in_ack | output | 1 | Input word consumed this cycle |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| out_data | output | 16 | Output port word |

## Verification
An ADD fetched right behind the two IN operations that produce its operands checks the read-after-write interlock. Without the stall it would carry stale register values and print a wrong sum. Sums and differences are swept over pairs that include 0, 0x7FFF, 0x8000 and 0xFFFF, with the input port withheld for varying gaps. This catches wraparound errors, and an IN that does not wait would consume garbage. A countdown loop built from taken and untaken branches checks the redirect and flush. A wrong target or a leftover queue entry shows up as a wrong or extra output. A first output of an unwritten register checks the reset state, and an all-ones opcode-7 word checks that the NOP has no side effects.

// File: rtl/duo_pkg.sv
package duo_pkg;

    localparam int DW     = 16;
    localparam int RA_W   = 2;
    localparam int REG_N  = 1 << RA_W;

    typedef enum logic [2:0] {
        OP_LDI  = 3'd0,
        OP_LDPC = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_BZ   = 3'd4,
        OP_OUT  = 3'd5,
        OP_IN   = 3'd6,
        OP_NOP  = 3'd7
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [RA_W-1:0] rd;
        logic [DW-1:0]   va;
        logic [DW-1:0]   vb;
    } dop_t;

    function automatic logic op_writes(op_e op);
        return (op == OP_LDI) || (op == OP_LDPC) || (op == OP_ADD) ||
               (op == OP_SUB) || (op == OP_IN);
    endfunction

    function automatic logic op_uses_a(op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_BZ) || (op == OP_OUT);
    endfunction

    function automatic logic op_uses_b(op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_BZ);
    endfunction

endpackage

// File: rtl/duo_regfile.sv
module duo_regfile
    import duo_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RA_W-1:0] ra_a,
    input  logic [RA_W-1:0] ra_b,
    output logic [DW-1:0]   rd_a,
    output logic [DW-1:0]   rd_b,
    input  logic            we,
    input  logic [RA_W-1:0] wa,
    input  logic [DW-1:0]   wd
);
    logic [DW-1:0] regs [REG_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
endmodule

// File: rtl/duo_queue.sv
module duo_queue
    import duo_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enq,
    input  dop_t            din,
    input  logic            deq,
    input  logic            flush,
    output dop_t            head,
    output logic            full,
    output logic            empty,
    output logic [DEPTH-1:0] live,
    output op_e             slot_op [DEPTH],
    output logic [RA_W-1:0] slot_rd [DEPTH]
);
    localparam int CW = $clog2(DEPTH + 1);

    dop_t          slots [DEPTH];
    logic [CW-1:0] count;
    logic [CW-1:0] wr_idx;

    assign full   = (count == CW'(DEPTH));
    assign empty  = (count == '0);
    assign head   = slots[0];
    assign wr_idx = deq ? (count - CW'(1)) : count;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign live[g]    = (CW'(g) < count);
        assign slot_op[g] = slots[g].op;
        assign slot_rd[g] = slots[g].rd;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            count <= '0;
        end else begin
            if (deq) begin
                for (int i = 0; i < DEPTH - 1; i++) slots[i] <= slots[i+1];
            end
            if (enq) slots[wr_idx] <= din;
            count <= count + CW'(enq) - CW'(deq);
        end
    end

    assert_enq_not_full_R8: assert property (@(posedge clk) disable iff (rst)
        enq |-> !full);

    assert_count_grows_R8: assert property (@(posedge clk) disable iff (rst)
        (enq && !deq && !flush) |=> (count == $past(count) + CW'(1)));

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);
endmodule

// File: rtl/duo_fetch.sv
module duo_fetch
    import duo_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int PM_AW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pm_we,
    input  logic [PM_AW-1:0] pm_addr,
    input  logic [DW-1:0]    pm_wdata,
    output logic [RA_W-1:0]  ra_a,
    output logic [RA_W-1:0]  ra_b,
    input  logic [DW-1:0]    rf_a,
    input  logic [DW-1:0]    rf_b,
    input  logic             q_full,
    input  logic [DEPTH-1:0] q_live,
    input  op_e              q_op [DEPTH],
    input  logic [RA_W-1:0]  q_rd [DEPTH],
    input  logic             redirect,
    input  logic [DW-1:0]    target,
    output logic             enq,
    output dop_t             dout
);
    localparam int PM_N = 1 << PM_AW;

    logic [DW-1:0]   pmem [PM_N];
    logic [DW-1:0]   pc;
    logic [DW-1:0]   word;
    op_e             op;
    logic [RA_W-1:0] rd;
    logic            raw_hit;
    logic            br_wait;

    always_ff @(posedge clk) begin
        if (pm_we) pmem[pm_addr] <= pm_wdata;
    end

    assign word = pmem[pc[PM_AW-1:0]];
    assign op   = op_e'(word[15:13]);
    assign rd   = word[12:11];
    assign ra_a = word[10:9];
    assign ra_b = word[8:7];

    always_comb begin
        raw_hit = 1'b0;
        br_wait = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_live[i]) begin
                if (q_op[i] == OP_BZ) br_wait = 1'b1;
                if (op_writes(q_op[i]) &&
                    ((op_uses_a(op) && q_rd[i] == ra_a) ||
                     (op_uses_b(op) && q_rd[i] == ra_b)))
                    raw_hit = 1'b1;
            end
        end
    end

    always_comb begin
        dout.op = op;
        dout.rd = rd;
        dout.vb = rf_b;
        case (op)
            OP_LDI:  dout.va = {{(DW-11){word[10]}}, word[10:0]};
            OP_LDPC: dout.va = pc;
            default: dout.va = rf_a;
        endcase
    end

    assign enq = !rst && !redirect && !q_full && !raw_hit && !br_wait;

    always_ff @(posedge clk) begin
        if (rst)           pc <= '0;
        else if (redirect) pc <= target;
        else if (enq)      pc <= pc + DW'(1);
    end

    assert_redirect_pc_R5: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (pc == $past(target)));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
        (enq && !redirect) |=> (pc == $past(pc) + DW'(1)));
endmodule

// File: rtl/duo_exec.sv
module duo_exec
    import duo_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  dop_t            head,
    input  logic            head_live,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_data,
    output logic            in_ack,
    output logic            deq,
    output logic            redirect,
    output logic [DW-1:0]   target,
    output logic            rf_we,
    output logic [RA_W-1:0] rf_wa,
    output logic [DW-1:0]   rf_wd,
    output logic            out_valid,
    output logic [DW-1:0]   out_data
);
    logic out_fire;

    always_comb begin
        deq      = 1'b0;
        redirect = 1'b0;
        rf_we    = 1'b0;
        rf_wd    = head.va;
        out_fire = 1'b0;
        in_ack   = 1'b0;
        if (head_live) begin
            case (head.op)
                OP_LDI, OP_LDPC: begin
                    deq = 1'b1; rf_we = 1'b1;
                end
                OP_ADD: begin
                    deq = 1'b1; rf_we = 1'b1; rf_wd = head.va + head.vb;
                end
                OP_SUB: begin
                    deq = 1'b1; rf_we = 1'b1; rf_wd = head.va - head.vb;
                end
                OP_BZ: begin
                    deq = 1'b1; redirect = (head.va == '0);
                end
                OP_OUT: begin
                    deq = 1'b1; out_fire = 1'b1;
                end
                OP_IN: begin
                    in_ack = in_valid; deq = in_valid; rf_we = in_valid; rf_wd = in_data;
                end
                default: deq = 1'b1;
            endcase
        end
    end

    assign target = head.vb;
    assign rf_wa  = head.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= out_fire;
            if (out_fire) out_data <= head.va;
        end
    end
endmodule

// File: rtl/duo_core.sv
module duo_core
    import duo_pkg::*;
#(
    parameter int QDEPTH = 2,
    parameter int PM_AW  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pm_we,
    input  logic [PM_AW-1:0] pm_addr,
    input  logic [15:0]      pm_wdata,
    input  logic             in_valid,
    input  logic [15:0]      in_data,
    output logic             in_ack,
    output logic             out_valid,
    output logic [15:0]      out_data
);
    logic [RA_W-1:0]   ra_a, ra_b, rf_wa;
    logic [DW-1:0]     rf_a, rf_b, rf_wd, target;
    logic              rf_we, enq, deq, redirect, q_full, q_empty;
    logic [QDEPTH-1:0] q_live;
    op_e               q_op [QDEPTH];
    logic [RA_W-1:0]   q_rd [QDEPTH];
    dop_t              dec, head;

    duo_regfile u_rf (
        .clk(clk), .rst(rst), .ra_a(ra_a), .ra_b(ra_b), .rd_a(rf_a), .rd_b(rf_b),
        .we(rf_we), .wa(rf_wa), .wd(rf_wd)
    );

    duo_fetch #(.DEPTH(QDEPTH), .PM_AW(PM_AW)) u_fetch (
        .clk(clk), .rst(rst), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .ra_a(ra_a), .ra_b(ra_b), .rf_a(rf_a), .rf_b(rf_b),
        .q_full(q_full), .q_live(q_live), .q_op(q_op), .q_rd(q_rd),
        .redirect(redirect), .target(target), .enq(enq), .dout(dec)
    );

    duo_queue #(.DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst(rst), .enq(enq), .din(dec), .deq(deq), .flush(redirect),
        .head(head), .full(q_full), .empty(q_empty), .live(q_live),
        .slot_op(q_op), .slot_rd(q_rd)
    );

    duo_exec u_exec (
        .clk(clk), .rst(rst), .head(head), .head_live(!q_empty),
        .in_valid(in_valid), .in_data(in_data), .in_ack(in_ack),
        .deq(deq), .redirect(redirect), .target(target),
        .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
        .out_valid(out_valid), .out_data(out_data)
    );

    assert_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!q_empty && head.op == OP_IN && !in_valid) |=> (!q_empty && head.op == OP_IN));
endmodule

// File: tb/tb_duo_core.sv
module tb_duo_core;
    localparam int CLK_PERIOD = 10;
    localparam int PM_AW = 6;

    logic clk = 0, rst = 1;
    logic pm_we = 0;
    logic [PM_AW-1:0] pm_addr = '0;
    logic [15:0] pm_wdata = '0;
    logic in_valid;
    logic [15:0] in_data;
    logic in_ack, out_valid;
    logic [15:0] out_data;

    duo_core #(.QDEPTH(2), .PM_AW(PM_AW)) dut (
        .clk(clk), .rst(rst), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .in_valid(in_valid), .in_data(in_data), .in_ack(in_ack),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    logic [15:0] prog [64];
    logic [15:0] ins [4];
    logic [15:0] expv [16];
    logic [15:0] got [32];
    int nexp = 0, ocount = 0, iidx = 0, gap = 0, gcnt = 0;
    int bad_ack = 0;

    assign in_valid = (gcnt == 0);
    assign in_data  = ins[iidx & 3];

    always @(posedge clk) begin
        if (rst) begin
            ocount <= 0; iidx <= 0; gcnt <= 0;
        end else begin
            if (out_valid) begin
                if (ocount < 32) got[ocount] <= out_data;
                ocount <= ocount + 1;
            end
            if (in_ack) begin
                iidx <= iidx + 1;
                if (!in_valid) bad_ack <= bad_ack + 1;
            end
            gcnt <= (gcnt >= gap) ? 0 : gcnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] ir(int op, int rd, int ra, int rb);
        return {op[2:0], rd[1:0], ra[1:0], rb[1:0], 7'd0};
    endfunction
    function automatic logic [15:0] ldi(int rd, int imm);
        return {3'd0, rd[1:0], imm[10:0]};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run(string name, int nin, bit first);
        int n;
        rst = 1;
        @(negedge clk);
        for (int a = 0; a < 64; a++) begin
            pm_we = 1; pm_addr = a[PM_AW-1:0]; pm_wdata = prog[a];
            @(negedge clk);
        end
        pm_we = 0;
        if (first) begin
            chk("R1 out_valid in reset", {15'd0, out_valid}, 16'd0);
            chk("R1 in_ack in reset", {15'd0, in_ack}, 16'd0);
        end
        rst = 0;
        n = 0;
        while (ocount < nexp && n < 4000) begin
            @(negedge clk); n++;
        end
        repeat (30) @(negedge clk);
        chk({name, " R6 output count"}, ocount[15:0], nexp[15:0]);
        chk({name, " R7 inputs consumed"}, iidx[15:0], nin[15:0]);
        chk({name, " R7 ack without valid"}, bad_ack[15:0], 16'd0);
        for (int k = 0; k < nexp && k < ocount; k++)
            chk($sformatf("%s word %0d", name, k), got[k], expv[k]);
    endtask

    logic [15:0] vals [6];

    initial begin
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002;
        vals[3] = 16'h7fff; vals[4] = 16'h8000; vals[5] = 16'hffff;

        // Sweep A: R1 reset regs, R3 arithmetic, R4 interlock, R7 input waits, R9 NOP
        for (int i = 0; i < 64; i++) prog[i] = 16'hffff;
        prog[0]  = ir(5, 0, 3, 0);   // OUT r3 -> 0 after reset (R1)
        prog[1]  = ir(6, 0, 0, 0);   // IN r0
        prog[2]  = ir(6, 1, 0, 0);   // IN r1
        prog[3]  = ir(2, 2, 0, 1);   // ADD r2 = r0 + r1 (R4 stall)
        prog[4]  = ir(5, 0, 2, 0);
        prog[5]  = ir(3, 3, 0, 1);   // SUB r3 = r0 - r1
        prog[6]  = ir(5, 0, 3, 0);
        prog[7]  = ir(3, 3, 1, 0);   // SUB r3 = r1 - r0
        prog[8]  = ir(5, 0, 3, 0);
        prog[9]  = 16'hffff;         // opcode 7, all fields set (R9)
        prog[10] = ir(5, 0, 3, 0);
        prog[11] = ldi(2, 0);
        prog[12] = ldi(3, 13);
        prog[13] = ir(4, 0, 2, 3);   // BZ r2 -> r3 : spin at 13
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                ins[0] = vals[i]; ins[1] = vals[j]; ins[2] = 0; ins[3] = 0;
                gap = (i + j) % 3;
                bad_ack = 0;
                nexp = 5;
                expv[0] = 16'h0000;
                expv[1] = vals[i] + vals[j];
                expv[2] = vals[i] - vals[j];
                expv[3] = vals[j] - vals[i];
                expv[4] = vals[j] - vals[i];
                run($sformatf("R1 R3 R4 R9 a=%h b=%h", vals[i], vals[j]), 2, (i == 0 && j == 0));
            end
        end

        // Sweep B: R2 sign-extended LDI and LDPC, R5 branch loop, R8 back-to-back queue use
        for (int i = 0; i < 64; i++) prog[i] = 16'hffff;
        prog[0]  = ir(6, 0, 0, 0);   // IN r0 = n
        prog[1]  = ldi(1, -1);       // r1 = 0xffff
        prog[2]  = ldi(2, 0);        // r2 = 0
        prog[3]  = 16'he000;         // NOP
        prog[4]  = ir(5, 0, 0, 0);   // loop: OUT r0
        prog[5]  = ir(2, 0, 0, 1);   // r0 = r0 - 1
        prog[6]  = ldi(3, 10);
        prog[7]  = ir(4, 0, 0, 3);   // BZ r0 -> 10
        prog[8]  = ldi(3, 4);
        prog[9]  = ir(4, 0, 2, 3);   // BZ r2 -> 4 (always taken)
        prog[10] = ir(1, 1, 0, 0);   // LDPC r1 -> 10
        prog[11] = ir(5, 0, 1, 0);
        prog[12] = ldi(3, 13);
        prog[13] = ir(4, 0, 2, 3);
        for (int n = 1; n <= 12; n++) begin
            ins[0] = n[15:0]; ins[1] = 0; ins[2] = 0; ins[3] = 0;
            gap = n % 4;
            bad_ack = 0;
            nexp = n + 1;
            for (int k = 0; k < n; k++) expv[k] = 16'(n - k);
            expv[n] = 16'd10;
            run($sformatf("R2 R5 R8 n=%0d", n), 1, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule